// File: doc/BRIEF.md
# NAPOT-Aware Page Table Entry Checker

This block judges one 64-bit page table entry returned during a multi-level page walk of the 39-bit or 48-bit virtual address kind. Given the entry, the level at which it was fetched, the number of levels in the walk and the virtual address being translated, it decides in one pass whether the entry is unusable, points to the next table, or ends the walk as a leaf. For a pointer it yields the base address of the next table. For a leaf it forms the physical address: superpages take their low page-number bits from the virtual address, and contiguous 64 KiB mappings splice four virtual page bits into the page number.

A contiguity flag in the top bit of the entry marks a naturally aligned power-of-two mapping. The mapping size is encoded by the trailing zeros of the page number. Only the 64 KiB size is accepted, and only at the last level of the walk. An enable input decides whether the flag means anything on a leaf. The flag is never legal on a pointer entry.

A walk sequencer drives the inputs and reads the verdict. A build-time parameter can add one register stage behind the logic, so that the result arrives one clock later.

Top module: `napot_pte_judge`

## Requirements
- R1: Field positions: V is bit 0, R bit 1, W bit 2, X bit 3, U bit 4, A bit 6, D bit 7, the page number occupies bits 53:10 and the contiguity flag is bit 63. `perm_o` always carries the entry's raw bits as {U,X,W,R}, from bit 3 down to bit 0.
- R2: An entry with V clear gives `fault_o`=1, with `leaf_o`=0 and both addresses zero.
- R3: An entry with V set and R, W and X all clear, and with none of D, A, U or the flag set, gives no fault and no leaf. `next_base_o` is then the page number shifted left by 12.
- R4: A pointer entry with any of D, A, U or the flag set faults, whatever the enable input says.
- R5: A leaf without a contiguous mapping gives `pa_o` = ((page number OR (VPN AND (2^s − 1))) << 12) OR va[11:0], where VPN = va[47:12] and s = 9 × (levels − 1 − level). Level 0 is the root.
- R6: When the enable is high and a leaf has the flag set, the size count is (trailing zeros of the page number) + 1. The leaf faults unless the count is exactly 4 and the level equals levels − 1.
- R7: A legal contiguous leaf has the low 4 page-number bits of `pa_o` (bits 15:12) taken from VPN[3:0]. The upper page-number bits come from the entry.
- R8: When the enable is low, the flag has no effect on a leaf, and the address is formed as in R5.
- R9: A flagged leaf whose page number is all zeros faults when the enable is high.
- R10: With `REG_OUT`=1, all outputs are zero while reset is held. After reset they show the result for the inputs present at the previous rising clock edge.
- R11: Whenever `fault_o` is 1, `leaf_o` is 0 and `pa_o` and `next_base_o` are zero. `next_base_o` is zero for every entry that is not an accepted pointer.

Ports of the default build: `PPN_W`=44, `VA_W`=48, `LVL_W`=3, giving `PA_W`=56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low reset |
| pte_i | input | 64 | Page table entry under judgement |
| lvl_i | input | LVL_W | Level at which the entry was fetched, 0 = root |
| nlvl_i | input | LVL_W | Number of levels in the walk |
| va_i | input | VA_W | Virtual address being translated |
| napot_en_i | input | 1 | Gives the contiguity flag its meaning on leaves |
| fault_o | output | 1 | Translation fault |
| next_base_o | output | PA_W | Base address of the next table for an accepted pointer |
| leaf_o | output | 1 | Entry is an accepted leaf |
| pa_o | output | PA_W | Physical address for an accepted leaf |
| perm_o | output | 4 | Raw {U,X,W,R} bits of the entry |

## Verification
Every cycle, the assertions check these rules: an invalid entry always faults, a fault never comes with a leaf or an address, an accepted pointer is neither fault nor leaf, a leaf keeps the page offset, a flagged leaf is only accepted at the last level with its low four page bits taken from the virtual address, a flagged entry with a zero page number is rejected, and the registered build follows the logic by one cycle. The full addresses need a reference computation, so only the bench's scenarios can show them. The same holds for each cause of fault on a pointer, for the superpage splice at the different levels, for rejected sizes other than 64 KiB, and for the flag being ignored when the enable is low.

// File: rtl/napj_pkg.sv
package napj_pkg;

  // Entry field positions; decoding depends on these.
  localparam int unsigned V_POS    = 0;
  localparam int unsigned R_POS    = 1;
  localparam int unsigned W_POS    = 2;
  localparam int unsigned X_POS    = 3;
  localparam int unsigned U_POS    = 4;
  localparam int unsigned A_POS    = 6;
  localparam int unsigned D_POS    = 7;
  localparam int unsigned PPN_LSB  = 10;
  localparam int unsigned FLAG_POS = 63;

  localparam int unsigned PG_SHIFT = 12;
  localparam int          IDX_BITS = 9;

  typedef enum logic [1:0] {
    KIND_INVALID = 2'd0,
    KIND_POINTER = 2'd1,
    KIND_LEAF    = 2'd2
  } pte_kind_e;

  // Count of zero bits below the lowest set bit among the low w bits; w if none.
  function automatic logic [6:0] trail_zeros(input logic [63:0] v, input int unsigned w);
    logic [6:0] n;
    logic       hit;
    n   = 7'(w);
    hit = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (!hit && (i < int'(w)) && v[i]) begin
        n   = 7'(i);
        hit = 1'b1;
      end
    end
    return n;
  endfunction

  // Mask with the n low bits set.
  function automatic logic [63:0] low_ones(input logic [6:0] n);
    if (n >= 7'd64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

endpackage

// File: rtl/napj_decode.sv
module napj_decode
  import napj_pkg::*;
#(
  parameter int PPN_W = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      pte,
  output pte_kind_e        kind,
  output logic             inner_bad,
  output logic             flag,
  output logic [PPN_W-1:0] ppn,
  output logic [3:0]       perm
);

  localparam int PPN_TOP = PPN_LSB + PPN_W;

  logic rwx_none;
  logic inner_marks;

  always_comb begin
    perm        = {pte[U_POS], pte[X_POS], pte[W_POS], pte[R_POS]};
    flag        = pte[FLAG_POS];
    ppn         = pte[PPN_LSB +: PPN_W];
    rwx_none    = !(pte[R_POS] | pte[W_POS] | pte[X_POS]);
    inner_marks = pte[D_POS] | pte[A_POS] | pte[U_POS] | flag;
    if (!pte[V_POS])   kind = KIND_INVALID;
    else if (rwx_none) kind = KIND_POINTER;
    else               kind = KIND_LEAF;
    inner_bad = (kind == KIND_POINTER) && inner_marks;
  end

  logic unused_bits;
  assign unused_bits = ^{pte[9:8], pte[5], pte[FLAG_POS-1:PPN_TOP]};

  // R4: the flag on a pointer is always rejected
  assert_inner_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pte[V_POS] && !pte[R_POS] && !pte[W_POS] && !pte[X_POS] && pte[FLAG_POS]) |-> inner_bad);

endmodule

// File: rtl/napj_napot.sv
module napj_napot
  import napj_pkg::*;
#(
  parameter int PPN_W    = 44,
  parameter int LVL_W    = 3,
  parameter int REQ_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             flag,
  input  logic             is_leaf,
  input  logic [PPN_W-1:0] ppn,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] nlvl,
  output logic [6:0]       nap_cnt,
  output logic             nap_bad
);

  logic [6:0] size_cnt;
  logic       active;
  logic       at_final;

  always_comb begin
    size_cnt = trail_zeros(64'(ppn), PPN_W) + 7'd1;
    active   = en && flag && is_leaf;
    at_final = (lvl == (nlvl - LVL_W'(1)));
    nap_cnt  = active ? size_cnt : 7'd0;
    nap_bad  = active && (!at_final || (size_cnt != 7'(REQ_BITS)));
  end

  // R9: an all-zero page number can never encode the accepted size
  assert_zero_ppn_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flag && is_leaf && (ppn == '0)) |-> nap_bad);

endmodule

// File: rtl/napj_pa_form.sv
module napj_pa_form
  import napj_pkg::*;
#(
  parameter int  PPN_W = 44,
  parameter int  VA_W  = 48,
  parameter int  LVL_W = 3,
  localparam int VPN_W = VA_W - PG_SHIFT,
  localparam int PA_W  = PPN_W + PG_SHIFT
) (
  input  logic [PPN_W-1:0] ppn,
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] nlvl,
  input  logic [6:0]       nap_cnt,
  output logic [PA_W-1:0]  pa
);

  // Superpage shift: nine index bits per level below the current one.
  function automatic logic [6:0] sp_shift(input logic [LVL_W-1:0] l, input logic [LVL_W-1:0] n);
    int d;
    if (l >= n) return 7'd0;
    d = int'(n) - 1 - int'(l);
    return 7'(IDX_BITS * d);
  endfunction

  // High page bits from the entry, low bits spliced from the virtual page.
  function automatic logic [PPN_W-1:0] splice_page(input logic [PPN_W-1:0] p,
                                                   input logic [VPN_W-1:0] v,
                                                   input logic [6:0]       ncnt,
                                                   input logic [6:0]       scnt);
    logic [63:0] nm, sm, p64, v64, r;
    nm  = low_ones(ncnt);
    sm  = low_ones(scnt);
    p64 = 64'(p);
    v64 = 64'(v);
    r   = (p64 & ~nm) | (v64 & nm) | (v64 & sm);
    return r[PPN_W-1:0];
  endfunction

  logic [PPN_W-1:0] page;

  always_comb begin
    page = splice_page(ppn, va[VA_W-1:PG_SHIFT], nap_cnt, sp_shift(lvl, nlvl));
    pa   = {page, va[PG_SHIFT-1:0]};
  end

endmodule

// File: rtl/napot_pte_judge.sv
module napot_pte_judge
  import napj_pkg::*;
#(
  parameter int  PPN_W     = 44,
  parameter int  VA_W      = 48,
  parameter int  LVL_W     = 3,
  parameter int  NAPOT_REQ = 4,
  parameter bit  REG_OUT   = 1'b0,
  localparam int PA_W      = PPN_W + PG_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      pte_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] nlvl_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             napot_en_i,
  output logic             fault_o,
  output logic [PA_W-1:0]  next_base_o,
  output logic             leaf_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [3:0]       perm_o
);

  pte_kind_e        kind;
  logic             inner_bad;
  logic             flag;
  logic [PPN_W-1:0] ppn;
  logic [3:0]       perm_c;
  logic [6:0]       nap_cnt;
  logic             nap_bad;
  logic [PA_W-1:0]  pa_raw;
  logic             is_leaf;

  napj_decode #(.PPN_W(PPN_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .pte(pte_i), .kind(kind), .inner_bad(inner_bad),
    .flag(flag), .ppn(ppn), .perm(perm_c)
  );

  assign is_leaf = (kind == KIND_LEAF);

  napj_napot #(.PPN_W(PPN_W), .LVL_W(LVL_W), .REQ_BITS(NAPOT_REQ)) u_napot (
    .clk(clk), .rst_n(rst_n), .en(napot_en_i), .flag(flag), .is_leaf(is_leaf),
    .ppn(ppn), .lvl(lvl_i), .nlvl(nlvl_i), .nap_cnt(nap_cnt), .nap_bad(nap_bad)
  );

  napj_pa_form #(.PPN_W(PPN_W), .VA_W(VA_W), .LVL_W(LVL_W)) u_pa (
    .ppn(ppn), .va(va_i), .lvl(lvl_i), .nlvl(nlvl_i), .nap_cnt(nap_cnt), .pa(pa_raw)
  );

  // Verdict before the optional register stage.
  logic            fault_c;
  logic            leaf_c;
  logic [PA_W-1:0] base_c;
  logic [PA_W-1:0] pa_c;

  always_comb begin
    fault_c = (kind == KIND_INVALID) || inner_bad || nap_bad;
    leaf_c  = is_leaf && !nap_bad;
    base_c  = (kind == KIND_POINTER && !inner_bad) ? {ppn, {PG_SHIFT{1'b0}}} : '0;
    pa_c    = leaf_c ? pa_raw : '0;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic past_ok;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fault_o     <= 1'b0;
          next_base_o <= '0;
          leaf_o      <= 1'b0;
          pa_o        <= '0;
          perm_o      <= '0;
          past_ok     <= 1'b0;
        end else begin
          fault_o     <= fault_c;
          next_base_o <= base_c;
          leaf_o      <= leaf_c;
          pa_o        <= pa_c;
          perm_o      <= perm_c;
          past_ok     <= 1'b1;
        end
      end

      // R10: registered outputs trail the logic by one cycle
      assert_reg_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (fault_o == $past(fault_c)) && (leaf_o == $past(leaf_c)) &&
                    (pa_o == $past(pa_c)) && (next_base_o == $past(base_c)));
    end else begin : g_comb
      always_comb begin
        fault_o     = fault_c;
        next_base_o = base_c;
        leaf_o      = leaf_c;
        pa_o        = pa_c;
        perm_o      = perm_c;
      end
    end
  endgenerate

  // R2: a cleared V bit always faults with nothing else asserted
  assert_invalid_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pte_i[V_POS] |-> (fault_c && !leaf_c && (base_c == '0) && (pa_c == '0)));

  // R11: a fault carries neither a leaf nor an address
  assert_fault_excl_leaf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_c |-> (!leaf_c && (pa_c == '0) && (base_c == '0)));

  // R3: an accepted pointer is neither a fault nor a leaf
  assert_ptr_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (base_c != '0) |-> (!fault_c && !leaf_c));

  // R5: a leaf keeps the page offset of the virtual address
  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_c |-> (pa_c[PG_SHIFT-1:0] == va_i[PG_SHIFT-1:0]));

  // R6: a flagged leaf is only accepted at the last level
  assert_napot_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (leaf_c && napot_en_i && pte_i[FLAG_POS]) |-> (lvl_i == (nlvl_i - LVL_W'(1))));

  // R7: an accepted contiguous leaf takes its low page bits from the virtual page
  assert_napot_splice_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (leaf_c && napot_en_i && pte_i[FLAG_POS]) |->
      (pa_c[PG_SHIFT +: NAPOT_REQ] == va_i[PG_SHIFT +: NAPOT_REQ]));

endmodule

// File: tb/test_napot_pte_judge.sv
module test_napot_pte_judge;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pte = '0;
  logic [2:0]  lvl = '0;
  logic [2:0]  nlvl = 3'd3;
  logic [47:0] va = '0;
  logic        en = 1'b0;

  logic        fault_c, leaf_c, fault_r, leaf_r;
  logic [55:0] base_c, pa_c, base_r, pa_r;
  logic [3:0]  perm_c, perm_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  napot_pte_judge i_napot_pte_judge (
    .clk(clk), .rst_n(rst_n), .pte_i(pte), .lvl_i(lvl), .nlvl_i(nlvl), .va_i(va),
    .napot_en_i(en), .fault_o(fault_c), .next_base_o(base_c), .leaf_o(leaf_c),
    .pa_o(pa_c), .perm_o(perm_c)
  );

  napot_pte_judge #(.REG_OUT(1'b1)) i_napot_pte_judge_reg (
    .clk(clk), .rst_n(rst_n), .pte_i(pte), .lvl_i(lvl), .nlvl_i(nlvl), .va_i(va),
    .napot_en_i(en), .fault_o(fault_r), .next_base_o(base_r), .leaf_o(leaf_r),
    .pa_o(pa_r), .perm_o(perm_r)
  );

  // Entry builder: {flag, 9 reserved, 44-bit page number, 2 software bits, D A G U X W R V}
  function automatic logic [63:0] mk(input logic f, input logic [43:0] p, input logic [7:0] lo);
    return {f, 9'd0, p, 2'b00, lo};
  endfunction

  // Reference verdict written straight from the requirements.
  task automatic expect_of(output logic ef, output logic el, output logic [55:0] eb,
                           output logic [55:0] ep, output logic [3:0] eperm);
    logic [43:0] p;
    logic [63:0] nmask, smask, v64, pg;
    int nb, sh, tz;
    p = pte[53:10];
    ef = 1'b0; el = 1'b0; eb = '0; ep = '0;
    eperm = {pte[4], pte[3], pte[2], pte[1]};
    if (pte[0] == 1'b0) begin
      ef = 1'b1;
    end else if (pte[3:1] == 3'b000) begin
      if (pte[7] || pte[6] || pte[4] || pte[63]) ef = 1'b1;
      else eb = {p, 12'h000};
    end else begin
      nb = 0;
      if (en && pte[63]) begin
        tz = 0;
        while (tz < 44 && p[tz] == 1'b0) tz++;
        nb = tz + 1;
        if ((int'(lvl) != int'(nlvl) - 1) || nb != 4) ef = 1'b1;
      end
      if (!ef) begin
        sh    = 9 * (int'(nlvl) - 1 - int'(lvl));
        nmask = (64'd1 << nb) - 64'd1;
        smask = (64'd1 << sh) - 64'd1;
        v64   = {28'd0, va[47:12]};
        pg    = ({20'd0, p} & ~nmask) | (v64 & nmask) | (v64 & smask);
        ep    = {pg[43:0], va[11:0]};
        el    = 1'b1;
      end
    end
  endtask

  task automatic compare(input string tag, input logic af, input logic al, input logic [55:0] ab,
                         input logic [55:0] ap, input logic [3:0] aperm);
    logic ef, el;
    logic [55:0] eb, ep;
    logic [3:0] eperm;
    expect_of(ef, el, eb, ep, eperm);
    checks++;
    if (af !== ef || al !== el || ab !== eb || ap !== ep || aperm !== eperm) begin
      errors++;
      $display("FAIL %s: got fault=%0b leaf=%0b base=%h pa=%h perm=%b, expected fault=%0b leaf=%0b base=%h pa=%h perm=%b",
               tag, af, al, ab, ap, aperm, ef, el, eb, ep, eperm);
    end
  endtask

  task automatic apply_check(input string tag, input logic [63:0] e, input logic [2:0] l,
                             input logic [2:0] n, input logic [47:0] a, input logic x);
    @(negedge clk);
    pte = e; lvl = l; nlvl = n; va = a; en = x;
    #1;
    compare(tag, fault_c, leaf_c, base_c, pa_c, perm_c);
  endtask

  task automatic flag_check(input string tag, input logic got, input logic want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, want);
    end
  endtask

  localparam logic [47:0] VA_A = 48'h7A5C_3B96_1E2F;
  localparam logic [47:0] VA_B = 48'h0123_4567_89AB;

  task automatic t_reset;
    pte = mk(1'b0, 44'h123, 8'hCF); lvl = 3'd2; nlvl = 3'd3; va = VA_A;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (fault_r !== 1'b0 || leaf_r !== 1'b0 || pa_r !== '0 || base_r !== '0 || perm_r !== '0) begin
      errors++;
      $display("FAIL R10 reset: got fault=%0b leaf=%0b pa=%h base=%h perm=%b expected all zero",
               fault_r, leaf_r, pa_r, base_r, perm_r);
    end
  endtask

  task automatic t_invalid;
    apply_check("R2 invalid leaf bits", mk(1'b0, 44'hABC, 8'hCE), 3'd2, 3'd3, VA_A, 1'b1);
    flag_check("R11 invalid has no leaf", leaf_c, 1'b0);
  endtask

  task automatic t_pointer_ok;
    apply_check("R3 pointer base", mk(1'b0, 44'h0_0012_3456, 8'h01), 3'd0, 3'd3, VA_A, 1'b1);
    flag_check("R3 pointer not fault", fault_c, 1'b0);
  endtask

  task automatic t_pointer_bad;
    apply_check("R4 pointer with D", mk(1'b0, 44'h55, 8'h81), 3'd0, 3'd4, VA_A, 1'b0);
    apply_check("R4 pointer with A", mk(1'b0, 44'h55, 8'h41), 3'd1, 3'd4, VA_A, 1'b0);
    apply_check("R4 pointer with U", mk(1'b0, 44'h55, 8'h11), 3'd1, 3'd3, VA_A, 1'b1);
    apply_check("R4 pointer with flag, enabled", mk(1'b1, 44'h58, 8'h01), 3'd0, 3'd3, VA_A, 1'b1);
    apply_check("R4 pointer with flag, disabled", mk(1'b1, 44'h58, 8'h01), 3'd0, 3'd3, VA_A, 1'b0);
    flag_check("R4 flag pointer faults", fault_c, 1'b1);
  endtask

  task automatic t_leaf4k;
    apply_check("R5 R1 4KiB rwx leaf", mk(1'b0, 44'h9_8765_4321, 8'hCF), 3'd2, 3'd3, VA_A, 1'b0);
    apply_check("R1 read-only user leaf perms", mk(1'b0, 44'h777, 8'h13), 3'd3, 3'd4, VA_B, 1'b1);
  endtask

  task automatic t_superpage;
    apply_check("R5 2MiB superpage", mk(1'b0, 44'h0_0ABC_DE00, 8'h4B), 3'd1, 3'd3, VA_A, 1'b0);
    apply_check("R5 512GiB superpage sv48", mk(1'b0, 44'h0_F000_0000, 8'h47), 3'd0, 3'd4, VA_B, 1'b1);
  endtask

  task automatic t_napot_ok;
    apply_check("R7 64KiB leaf sv39", mk(1'b1, 44'h0_00AB_CDE8, 8'hC7), 3'd2, 3'd3, VA_A, 1'b1);
    flag_check("R7 low nibble from va", (pa_c[15:12] == VA_A[15:12]) && leaf_c, 1'b1);
    apply_check("R7 64KiB leaf sv48", mk(1'b1, 44'h3_0000_1238, 8'hCB), 3'd3, 3'd4, VA_B, 1'b1);
  endtask

  task automatic t_napot_nonfinal;
    apply_check("R6 flagged leaf at middle level", mk(1'b1, 44'h0_00AB_CDE8, 8'hC7), 3'd1, 3'd3, VA_A, 1'b1);
    apply_check("R6 flagged leaf at root", mk(1'b1, 44'h0_00AB_CDE8, 8'hC7), 3'd0, 3'd4, VA_A, 1'b1);
  endtask

  task automatic t_napot_size;
    apply_check("R6 size count 3", mk(1'b1, 44'h0_00AB_CDE4, 8'hC7), 3'd2, 3'd3, VA_A, 1'b1);
    apply_check("R6 size count 7", mk(1'b1, 44'h0_00AB_CD40, 8'hC7), 3'd2, 3'd3, VA_A, 1'b1);
    apply_check("R6 size count 1", mk(1'b1, 44'h0_00AB_CDE1, 8'hC7), 3'd2, 3'd3, VA_A, 1'b1);
  endtask

  task automatic t_napot_zero;
    apply_check("R9 zero page number flagged", mk(1'b1, 44'h0, 8'hC7), 3'd2, 3'd3, VA_A, 1'b1);
    flag_check("R9 zero page faults", fault_c, 1'b1);
  endtask

  task automatic t_napot_disabled;
    apply_check("R8 flag ignored when disabled", mk(1'b1, 44'h0_00AB_CDE8, 8'hC7), 3'd2, 3'd3, VA_A, 1'b0);
    flag_check("R8 page nibble kept from entry", pa_c[15:12] == 4'h8, 1'b1);
    apply_check("R8 bad size ignored when disabled", mk(1'b1, 44'h0_00AB_CDE4, 8'hC7), 3'd1, 3'd3, VA_B, 1'b0);
  endtask

  task automatic t_registered;
    @(negedge clk);
    pte = mk(1'b0, 44'h0_0ABC_DE00, 8'h4B); lvl = 3'd1; nlvl = 3'd3; va = VA_B; en = 1'b0;
    @(posedge clk);
    #1;
    compare("R10 registered leaf", fault_r, leaf_r, base_r, pa_r, perm_r);
    @(negedge clk);
    pte = mk(1'b1, 44'h58, 8'h01); lvl = 3'd0;
    #1;
    flag_check("R10 register holds until edge", leaf_r, 1'b1);
    @(posedge clk);
    #1;
    compare("R10 registered pointer fault", fault_r, leaf_r, base_r, pa_r, perm_r);
  endtask

  initial begin
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_invalid;
    t_pointer_ok;
    t_pointer_bad;
    t_leaf4k;
    t_superpage;
    t_napot_ok;
    t_napot_nonfinal;
    t_napot_size;
    t_napot_zero;
    t_napot_disabled;
    t_registered;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule